// File: doc/BRIEF.md
# Trigger Throttle and Data-Path Flush Controller

This block merges the fill state of several data-path FIFOs, an event-builder pause request and a manual override into one registered busy line. Upstream trigger logic uses that line to hold back new triggers. For each contributing cause, a status bit records whether it has fired since software last cleared it.

The block also issues a single-cycle flush strobe to every data-path FIFO. The strobe fires when an event-counter-reset (ECR) strobe arrives, or when software writes a flush request. Both sources are gated by one enable bit.

Two 32-bit counters track trigger (L1A) strobes. One counts every L1A. The other counts only the L1As that arrive while busy is high, so that lost trigger bandwidth can be measured. Software reaches the block through two writable control registers with readback and a write-one-to-clear port for the status bits.

Top module: `busy_flush_ctrl`

## Requirements
- R1: When `mb_fifo_full` is high at a clock edge, `busy` is high in the cycle after that edge.
- R2: When `evid_fifo_full` or `hdr_fifo_full` is high at a clock edge, `busy` is high in the cycle after that edge.
- R3: `evt_fifo_afull` raises `busy` and its status bit only while control bit 10 (af_en) is 1. While that bit is 0 it affects neither.
- R4: Bit 24 of the second control register (manual busy) holds `busy` high while it is 1. While it is 0 it has no effect on `busy`.
- R5: When `pause_req` is high at a clock edge, `busy` is high in the cycle after that edge.
- R6: Control bit 1 (flush_en) gates the ECR path. While flush_en is 1, each edge that samples `ecr` high makes `flush` high for the next cycle. While flush_en is 0, `ecr` never produces `flush`.
- R7: Control bit 0 is a software flush request. It reads back as 1 for one cycle after the write and then clears itself. If flush_en is 1 during that cycle, one `flush` pulse follows. If flush_en is 0, no pulse follows.
- R8: `busy_status` latches the active causes, each bit staying set after its cause ends. The bit positions are: bit 0 mode-bits full, bit 1 event-ID full, bit 2 header full, bit 3 gated almost-full, bit 4 manual busy, bit 5 pause.
- R9: Writing `stat_clr_wr` clears each status bit whose `stat_clr_data` bit is 1. A bit whose cause is active in that same cycle stays set.
- R10: `l1a_count` increments by one at every edge that samples `l1a` high, and wraps from all ones to zero.
- R11: `l1a_busy_count` increments only at edges that sample both `l1a` and `busy` high.
- R12: Control bit 3 is a self-clearing counter-clear request. In the cycle after the write it resets both counters to zero, taking priority over an increment.
- R13: After reset, `busy`, `flush`, `busy_status`, both counters and both control registers are zero. `busy` is low in any cycle that follows an edge with no cause active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mb_fifo_full | input | 1 | Mode-bits FIFO full |
| evid_fifo_full | input | 1 | Event-ID FIFO full |
| hdr_fifo_full | input | 1 | Fragment-header FIFO full |
| evt_fifo_afull | input | 1 | Event FIFO almost full |
| pause_req | input | 1 | Pause request from the event builder |
| l1a | input | 1 | Trigger strobe |
| ecr | input | 1 | Event counter reset strobe |
| ctrl_wr | input | 1 | Write strobe, control register |
| ctrl_wdata | input | 32 | Control register write data |
| ctrl2_wr | input | 1 | Write strobe, second control register |
| ctrl2_wdata | input | 32 | Second control register write data |
| stat_clr_wr | input | 1 | Write-one-to-clear strobe for status |
| stat_clr_data | input | 6 | Status bits to clear |
| ctrl_rd | output | 32 | Control register readback |
| ctrl2_rd | output | 32 | Second control register readback |
| busy | output | 1 | Trigger throttle |
| flush | output | 1 | Flush strobe for all data-path FIFOs |
| busy_status | output | 6 | Sticky busy causes |
| l1a_count | output | 32 | All triggers |
| l1a_busy_count | output | 32 | Triggers seen while busy |

## Verification
A wrong gating mask or a lost cause appears on `busy` one cycle after the input edge. It also stays visible on `busy_status` until the next clear. A self-clear bit that does not drop shows on `ctrl_rd` within one cycle, as a repeated `flush` pulse or as counters stuck at zero. A counter that misses or double-counts an increment diverges from the bench model at the very next trigger, and the difference never heals.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  localparam int NCAUSE = 6;
  localparam int CNT_W = 32;
  localparam int REG_W = 32;

  localparam int C_MB = 0;
  localparam int C_EVID = 1;
  localparam int C_HDR = 2;
  localparam int C_AFULL = 3;
  localparam int C_MAN = 4;
  localparam int C_PAUSE = 5;

  localparam int CTL_SWFLUSH = 0;
  localparam int CTL_FLUSH_EN = 1;
  localparam int CTL_CNT_CLR = 3;
  localparam int CTL_AF_EN = 10;
  localparam int CTL2_MANUAL = 24;

  localparam logic [REG_W-1:0] SELF_CLR_MASK =
    (REG_W'(1) << CTL_SWFLUSH) | (REG_W'(1) << CTL_CNT_CLR);

  // Assemble the active-cause vector from the raw flags and the gating controls.
  function automatic logic [NCAUSE-1:0] gate_causes(
    input logic mb, input logic evid, input logic hdr, input logic af,
    input logic af_en, input logic man, input logic pause);
    logic [NCAUSE-1:0] v;
    v = '0;
    v[C_MB] = mb;
    v[C_EVID] = evid;
    v[C_HDR] = hdr;
    v[C_AFULL] = af & af_en;
    v[C_MAN] = man;
    v[C_PAUSE] = pause;
    return v;
  endfunction

  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur, input logic inc, input logic clr);
    if (clr) return '0;
    return cur + CNT_W'(inc);
  endfunction

  function automatic logic [NCAUSE-1:0] next_sticky(
    input logic [NCAUSE-1:0] cur, input logic [NCAUSE-1:0] clr_mask,
    input logic [NCAUSE-1:0] active);
    return (cur & ~clr_mask) | active;
  endfunction
endpackage

// File: rtl/bfc_ctrl_regs.sv
module bfc_ctrl_regs
  import bfc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic [REG_W-1:0] ctrl_wdata,
  input  logic             ctrl2_wr,
  input  logic [REG_W-1:0] ctrl2_wdata,
  output logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] ctrl2_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ctrl2_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_wdata;
      else         ctrl_q <= ctrl_q & ~SELF_CLR_MASK;
      if (ctrl2_wr) ctrl2_q <= ctrl2_wdata;
    end
  end

  // R7: a self-clearing bit with no new write drops on the next edge
  assert_selfclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CTL_SWFLUSH] && !ctrl_wr) |=> !ctrl_q[CTL_SWFLUSH]);
  assert_cntclr_selfclear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CTL_CNT_CLR] && !ctrl_wr) |=> !ctrl_q[CTL_CNT_CLR]);
endmodule

// File: rtl/bfc_busy_tree.sv
module bfc_busy_tree
  import bfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mb_full,
  input  logic              evid_full,
  input  logic              hdr_full,
  input  logic              evt_afull,
  input  logic              pause_req,
  input  logic              af_en,
  input  logic              manual,
  input  logic              stat_clr_wr,
  input  logic [NCAUSE-1:0] stat_clr_data,
  output logic              busy,
  output logic [NCAUSE-1:0] status
);
  logic [NCAUSE-1:0] cause_active;
  logic [NCAUSE-1:0] clr_mask;

  assign cause_active = gate_causes(mb_full, evid_full, hdr_full, evt_afull,
                                    af_en, manual, pause_req);
  assign clr_mask = stat_clr_wr ? stat_clr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      status <= '0;
    end else begin
      busy   <= |cause_active;
      status <= next_sticky(status, clr_mask, cause_active);
    end
  end

  assert_mb_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mb_full |=> busy);
  assert_fifo_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evid_full || hdr_full) |=> busy);
  assert_af_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_afull && af_en) |=> (busy && status[C_AFULL]));
  assert_manual_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    manual |=> busy);
  assert_pause_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |=> busy);
  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr_wr |=> ((status & $past(status)) == $past(status)));
  assert_idle_low_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(mb_full || evid_full || hdr_full || pause_req || manual ||
      (evt_afull && af_en)) |=> !busy);
endmodule

// File: rtl/bfc_flush_gen.sv
module bfc_flush_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic flush_en,
  input  logic ecr,
  input  logic sw_req,
  output logic flush
);
  logic flush_trig;

  assign flush_trig = flush_en & (ecr | sw_req);

  always_ff @(posedge clk) begin
    if (!rst_n) flush <= 1'b0;
    else        flush <= flush_trig;
  end

  // R6/R7: no flush unless the enable was set at the triggering edge
  assert_flush_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_en |=> !flush);
  assert_ecr_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_en && ecr) |=> flush);
  assert_sw_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_en && sw_req) |=> flush);
endmodule

// File: rtl/bfc_trig_count.sv
module bfc_trig_count
  import bfc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= next_count(count, inc, clr);
  end

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (count == $past(count) + CNT_W'($past(inc))));
  assert_count_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
endmodule

// File: rtl/busy_flush_ctrl.sv
module busy_flush_ctrl
  import bfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mb_fifo_full,
  input  logic              evid_fifo_full,
  input  logic              hdr_fifo_full,
  input  logic              evt_fifo_afull,
  input  logic              pause_req,
  input  logic              l1a,
  input  logic              ecr,
  input  logic              ctrl_wr,
  input  logic [31:0]       ctrl_wdata,
  input  logic              ctrl2_wr,
  input  logic [31:0]       ctrl2_wdata,
  input  logic              stat_clr_wr,
  input  logic [5:0]        stat_clr_data,
  output logic [31:0]       ctrl_rd,
  output logic [31:0]       ctrl2_rd,
  output logic              busy,
  output logic              flush,
  output logic [5:0]        busy_status,
  output logic [31:0]       l1a_count,
  output logic [31:0]       l1a_busy_count
);
  localparam int NCNT = 2;

  logic [REG_W-1:0] ctrl_q, ctrl2_q;
  logic [NCNT-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_val [NCNT];
  logic cnt_clr, busy_trig;

  bfc_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .ctrl2_wr(ctrl2_wr), .ctrl2_wdata(ctrl2_wdata),
    .ctrl_q(ctrl_q), .ctrl2_q(ctrl2_q));

  bfc_busy_tree u_busy (
    .clk(clk), .rst_n(rst_n),
    .mb_full(mb_fifo_full), .evid_full(evid_fifo_full),
    .hdr_full(hdr_fifo_full), .evt_afull(evt_fifo_afull),
    .pause_req(pause_req),
    .af_en(ctrl_q[CTL_AF_EN]), .manual(ctrl2_q[CTL2_MANUAL]),
    .stat_clr_wr(stat_clr_wr), .stat_clr_data(stat_clr_data),
    .busy(busy), .status(busy_status));

  bfc_flush_gen u_flush (
    .clk(clk), .rst_n(rst_n),
    .flush_en(ctrl_q[CTL_FLUSH_EN]), .ecr(ecr),
    .sw_req(ctrl_q[CTL_SWFLUSH]), .flush(flush));

  assign cnt_clr   = ctrl_q[CTL_CNT_CLR];
  assign busy_trig = l1a & busy;
  assign cnt_inc   = {busy_trig, l1a};

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    bfc_trig_count u_cnt (
      .clk(clk), .rst_n(rst_n),
      .inc(cnt_inc[i]), .clr(cnt_clr), .count(cnt_val[i]));
  end

  assign l1a_count      = cnt_val[0];
  assign l1a_busy_count = cnt_val[1];
  assign ctrl_rd        = ctrl_q;
  assign ctrl2_rd       = ctrl2_q;

  // R11: the busy-only counter never moves on an edge where the total does not
  assert_busy_subset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !l1a |=> $stable(l1a_busy_count) || $past(cnt_clr));
endmodule

// File: tb/sim_busy_flush_ctrl.sv
module sim_busy_flush_ctrl;
  localparam time TCLK = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mb, evid, hdr, af, pause, l1a, ecr;
  logic cwr, c2wr, swr;
  logic [31:0] cwd, c2wd;
  logic [5:0] sclr;
  logic [31:0] ctrl_rd, ctrl2_rd, cnt_all, cnt_busy;
  logic busy, flush;
  logic [5:0] status;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  logic [31:0] m_ctrl, m_ctrl2, m_all, m_bsy;
  logic m_busy, m_flush;
  logic [5:0] m_stat;

  always #(TCLK/2) clk = ~clk;

  busy_flush_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .mb_fifo_full(mb), .evid_fifo_full(evid), .hdr_fifo_full(hdr),
    .evt_fifo_afull(af), .pause_req(pause), .l1a(l1a), .ecr(ecr),
    .ctrl_wr(cwr), .ctrl_wdata(cwd), .ctrl2_wr(c2wr), .ctrl2_wdata(c2wd),
    .stat_clr_wr(swr), .stat_clr_data(sclr),
    .ctrl_rd(ctrl_rd), .ctrl2_rd(ctrl2_rd), .busy(busy), .flush(flush),
    .busy_status(status), .l1a_count(cnt_all), .l1a_busy_count(cnt_busy));

  function automatic logic [5:0] causes_of(logic [31:0] c, logic [31:0] c2);
    // order per R8: mb, evid, hdr, gated af, manual, pause
    return {pause, c2[24], af & c[10], hdr, evid, mb};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    mb = 0; evid = 0; hdr = 0; af = 0; pause = 0; l1a = 0; ecr = 0;
    cwr = 0; c2wr = 0; swr = 0; cwd = '0; c2wd = '0; sclr = '0;
  endtask

  // Advance one clock with the inputs already driven, update model, compare.
  task automatic step();
    logic [5:0] cv;
    logic [5:0] msk;
    @(posedge clk);
    cv = causes_of(m_ctrl, m_ctrl2);
    msk = swr ? sclr : 6'd0;
    m_flush = m_ctrl[1] & (ecr | m_ctrl[0]);
    m_all = m_ctrl[3] ? 32'd0 : m_all + 32'(l1a);
    m_bsy = m_ctrl[3] ? 32'd0 : m_bsy + 32'(l1a & m_busy);
    m_busy = |cv;
    m_stat = (m_stat & ~msk) | cv;
    m_ctrl = cwr ? cwd : (m_ctrl & ~32'h9);
    if (c2wr) m_ctrl2 = c2wd;
    #1;
    check("R13 busy", 32'(busy), 32'(m_busy));
    check("R6 flush", 32'(flush), 32'(m_flush));
    check("R8 status", 32'(status), 32'(m_stat));
    check("R10 l1a_count", cnt_all, m_all);
    check("R11 l1a_busy_count", cnt_busy, m_bsy);
    check("R7 ctrl_rd", ctrl_rd, m_ctrl);
    check("R4 ctrl2_rd", ctrl2_rd, m_ctrl2);
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    idle_inputs();
    m_ctrl = '0; m_ctrl2 = '0; m_all = '0; m_bsy = '0;
    m_busy = 0; m_flush = 0; m_stat = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R13 reset state
    check("R13 reset busy", 32'(busy), 0);
    check("R13 reset flush", 32'(flush), 0);
    check("R13 reset status", 32'(status), 0);
    check("R13 reset counters", cnt_all | cnt_busy, 0);

    // R1
    mb = 1; step();
    check("R1 mb full busy", 32'(busy), 1);
    step();
    check("R8 sticky after cause gone", 32'(status), 32'h01);
    check("R13 busy drops", 32'(busy), 0);
    // R9 clear, and clear while active
    swr = 1; sclr = 6'h01; step();
    check("R9 w1c clears", 32'(status), 0);
    evid = 1; swr = 1; sclr = 6'h02; step();
    check("R9 active cause survives clear", 32'(status), 32'h02);
    check("R2 evid full busy", 32'(busy), 1);
    hdr = 1; step();
    check("R2 header full busy", 32'(busy), 1);
    // R3
    swr = 1; sclr = 6'h3f; step();
    af = 1; step();
    check("R3 afull ignored when disabled", 32'(busy) | 32'(status), 0);
    cwr = 1; cwd = 32'h400; step();
    af = 1; step();
    check("R3 afull busy when enabled", {busy, status}, {1'b1, 6'h08});
    // R4 manual
    c2wr = 1; c2wd = 32'h0100_0000; step();
    step();
    check("R4 manual busy", 32'(busy), 1);
    c2wr = 1; c2wd = 32'h0; step();
    step();
    check("R4 manual off", 32'(busy), 0);
    // R5
    pause = 1; step();
    check("R5 pause busy", 32'(busy), 1);
    // R6 ecr without enable
    cwr = 1; cwd = 32'h0; step();
    ecr = 1; step();
    check("R6 ecr no flush disabled", 32'(flush), 0);
    cwr = 1; cwd = 32'h2; step();
    ecr = 1; step();
    check("R6 ecr flush", 32'(flush), 1);
    step();
    check("R6 flush one cycle", 32'(flush), 0);
    // R7 sw flush
    cwr = 1; cwd = 32'h3; step();
    check("R7 bit0 reads back", ctrl_rd, 32'h3);
    step();
    check("R7 sw flush pulse", {flush, ctrl_rd[0]}, 2'b10);
    step();
    check("R7 single pulse", 32'(flush), 0);
    cwr = 1; cwd = 32'h1; step();
    step();
    check("R7 no flush without enable", 32'(flush), 0);
    // R11
    mb = 1; step();
    l1a = 1; step();
    check("R11 busy trigger counted", cnt_busy, m_bsy);
    check("R10 all triggers counted", cnt_all, m_all);
    l1a = 1; step();
    check("R11 idle trigger not counted", cnt_busy, 32'd1);
    // R12
    cwr = 1; cwd = 32'h8; step();
    l1a = 1; step();
    check("R12 clear beats increment", cnt_all | cnt_busy, 0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      mb = ($urandom_range(0, 15) == 0);
      evid = ($urandom_range(0, 15) == 0);
      hdr = ($urandom_range(0, 15) == 0);
      af = ($urandom_range(0, 3) == 0);
      pause = ($urandom_range(0, 15) == 0);
      l1a = ($urandom_range(0, 1) == 1);
      ecr = ($urandom_range(0, 20) == 0);
      cwr = ($urandom_range(0, 30) == 0);
      cwd = {$urandom} & 32'h0000_040B;
      c2wr = ($urandom_range(0, 60) == 0);
      c2wd = ($urandom_range(0, 3) == 0) ? 32'h0100_0000 : 32'h0;
      swr = ($urandom_range(0, 10) == 0);
      sclr = 6'($urandom);
      step();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule